// File: doc/BRIEF.md
# Memory Write-Path Error Injector

This block sits on the write datapath of an ECC-protected memory controller. It lets software plant a controlled corruption in one write beat so that the downstream checker and error reporting can be exercised. Software points an indirect selector register at the injection target and picks one 16-byte quarter of a 64-byte line. It then writes an injection descriptor through a data port. The descriptor holds a word mask, a 16-bit flip vector and a one-shot write request.

Each write beat is 144 bits wide: eight 16-bit data words plus one 16-bit ECC word. Every beat carries its quadrant index. The injector registers every beat and adds one cycle of latency. When a write request is pending, ECC checking is enabled and the beat's quadrant matches the programmed one, the flip vector is XORed into every selected word. The request bit then clears in hardware. Software polls that bit to learn that the injection has happened.

Top module: `dram_err_injector`

## Requirements
- R1: After reset, `out_vld` is 0 and all three registers read back as zero, so no injection is pending.
- R2: `reg_addr` picks the register. Code 0 is control, with the ECC-enable flag in bit 22. Code 1 is the target selector, with the target code in [31:28] and the quadrant in [2:1]. Code 2 is the data port, with the word mask in [28:20], error-enable in 18, the write request in 17, the read request in 16 and the flip vector in [15:0]. Code 3 reads zero. Unlisted bits read zero. A data-port read returns the live state of the request bit.
- R3: A data-port write is ignored, and every stored field keeps its value, unless the target code is 0x8.
- R4: Each beat appears on `out_data` one cycle after it is accepted, with `out_vld` high for exactly that cycle. With no armed injection the beat is unchanged.
- R5: An injecting beat leaves with the flip vector XORed into data word k (bits [16k+15:16k], selected by mask bit k, k = 0..7) and into the ECC word (bits [143:128], selected by mask bit 8). Unselected words are unchanged.
- R6: The write request reads 0 after the corrupted beat is accepted. Later beats pass unchanged until software re-arms.
- R7: A beat whose quadrant tag differs from the programmed quadrant passes unchanged and leaves the request pending.
- R8: While ECC checking is disabled, no beat is corrupted and the request stays pending. Once checking is enabled, the next matching beat is corrupted.
- R9: The read-request and error-enable bits are stored and read back, but they have no effect on the write path.
- R10: When a data-port write lands in the same cycle as an injecting beat, that beat uses the old settings and the written values, including the request bit, take effect afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 target selector, 2 data port) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| beat_vld | input | 1 | Write beat valid |
| beat_quad | input | 2 | Quadrant index of the beat within its line |
| beat_data | input | 144 | Beat: eight data words plus the ECC word at the top |
| out_vld | output | 1 | Output beat valid |
| out_data | output | 144 | Beat, corrupted when an injection fires |

## Verification
The hardest case to reach is the collision. In it a data-port write re-arms the injector in the very cycle that a matching beat consumes the old request. The bench drives the register write and the beat at the same falling edge. It then checks that the beat carries the old vector, that the new vector is corrupting the next beat, and that the request reads back as set. The stimulus also holds a request pending across mismatched quadrants and across a period with ECC checking disabled, to show that the request is not consumed early.

// File: rtl/dram_inj_pkg.sv
package dram_inj_pkg;
  localparam int WORD_W     = 16;
  localparam int DATA_WORDS = 8;
  localparam int QUAD_W     = 2;
  localparam int REG_W      = 32;

  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_ADDR = 2'd1;
  localparam logic [1:0] RSEL_PORT = 2'd2;

  localparam int         CTRL_ECC_BIT = 22;
  localparam int         TGT_LSB      = 28;
  localparam int         TGT_W        = 4;
  localparam logic [3:0] TGT_ECC      = 4'h8;
  localparam int         QUAD_LSB     = 1;
  localparam int         MASK_LSB     = 20;
  localparam int         ERR_EN_BIT   = 18;
  localparam int         WR_REQ_BIT   = 17;
  localparam int         RD_REQ_BIT   = 16;

  // Flip pattern applied to one word of a beat
  function automatic logic [WORD_W-1:0] word_flip(input logic fire, input logic sel,
                                                  input logic [WORD_W-1:0] vec);
    return (fire && sel) ? vec : '0;
  endfunction

  function automatic logic quad_match(input logic [QUAD_W-1:0] a, input logic [QUAD_W-1:0] b);
    return a == b;
  endfunction
endpackage

// File: rtl/dram_inj_regs.sv
module dram_inj_regs
  import dram_inj_pkg::*;
#(
  parameter int VEC_W  = WORD_W,
  parameter int MASK_W = DATA_WORDS + 1,
  parameter int QW     = QUAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              inj_fire,
  output logic              ecc_en,
  output logic [QW-1:0]     quad_sel,
  output logic [MASK_W-1:0] word_mask,
  output logic [VEC_W-1:0]  err_vec,
  output logic              wr_req,
  output logic              rearm
);
  logic              ecc_en_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [QW-1:0]     quad_q;
  logic [MASK_W-1:0] mask_q;
  logic [VEC_W-1:0]  vec_q;
  logic              errena_q, wrreq_q, rdreq_q;

  logic ctrl_go, addr_go, port_go;
  assign ctrl_go = reg_wr && (reg_addr == RSEL_CTRL);
  assign addr_go = reg_wr && (reg_addr == RSEL_ADDR);
  assign port_go = reg_wr && (reg_addr == RSEL_PORT) && (tgt_q == TGT_ECC);
  assign rearm   = port_go && reg_wdata[WR_REQ_BIT];

  logic unused_wdata;
  assign unused_wdata = reg_wdata[19];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_en_q <= 1'b0;
      tgt_q    <= '0;
      quad_q   <= '0;
      mask_q   <= '0;
      vec_q    <= '0;
      errena_q <= 1'b0;
      wrreq_q  <= 1'b0;
      rdreq_q  <= 1'b0;
    end else begin
      if (ctrl_go) ecc_en_q <= reg_wdata[CTRL_ECC_BIT];
      if (addr_go) begin
        tgt_q  <= reg_wdata[TGT_LSB +: TGT_W];
        quad_q <= reg_wdata[QUAD_LSB +: QW];
      end
      if (port_go) begin
        mask_q   <= reg_wdata[MASK_LSB +: MASK_W];
        vec_q    <= reg_wdata[VEC_W-1:0];
        errena_q <= reg_wdata[ERR_EN_BIT];
        rdreq_q  <= reg_wdata[RD_REQ_BIT];
        wrreq_q  <= reg_wdata[WR_REQ_BIT];
      end else if (inj_fire) begin
        wrreq_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RSEL_CTRL: reg_rdata[CTRL_ECC_BIT] = ecc_en_q;
      RSEL_ADDR: begin
        reg_rdata[TGT_LSB +: TGT_W] = tgt_q;
        reg_rdata[QUAD_LSB +: QW]   = quad_q;
      end
      RSEL_PORT: begin
        reg_rdata[MASK_LSB +: MASK_W] = mask_q;
        reg_rdata[ERR_EN_BIT]         = errena_q;
        reg_rdata[WR_REQ_BIT]         = wrreq_q;
        reg_rdata[RD_REQ_BIT]         = rdreq_q;
        reg_rdata[VEC_W-1:0]          = vec_q;
      end
      default: ;
    endcase
  end

  assign ecc_en    = ecc_en_q;
  assign quad_sel  = quad_q;
  assign word_mask = mask_q;
  assign err_vec   = vec_q;
  assign wr_req    = wrreq_q;

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire && !port_go |=> !wrreq_q); // R6
  AST_IGNORED_PORT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == RSEL_PORT && tgt_q != TGT_ECC |=> $stable(vec_q) && $stable(mask_q)); // R3
  AST_PENDING_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wrreq_q && !ecc_en_q && !reg_wr |=> wrreq_q); // R8
endmodule

// File: rtl/dram_inj_path.sv
module dram_inj_path
  import dram_inj_pkg::*;
#(
  parameter int WW     = WORD_W,
  parameter int NDATA  = DATA_WORDS,
  parameter int QW     = QUAD_W,
  localparam int NWORD  = NDATA + 1,
  localparam int BEAT_W = WW * NWORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic [QW-1:0]     beat_quad,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic              arm,
  input  logic              ecc_en,
  input  logic [QW-1:0]     quad_sel,
  input  logic [NWORD-1:0]  word_mask,
  input  logic [WW-1:0]     err_vec,
  output logic              out_vld,
  output logic [BEAT_W-1:0] out_data,
  output logic              inj_fire
);
  logic [BEAT_W-1:0] beat_mod;

  assign inj_fire = beat_vld && arm && ecc_en && quad_match(beat_quad, quad_sel);

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign beat_mod[w*WW +: WW] = beat_data[w*WW +: WW] ^ word_flip(inj_fire, word_mask[w], err_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= beat_vld;
      if (beat_vld) out_data <= beat_mod;
    end
  end

  AST_LATENCY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |=> out_vld); // R4
  AST_SINGLE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |=> !out_vld); // R4
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && !inj_fire |=> out_data == $past(beat_data)); // R7
endmodule

// File: rtl/dram_err_injector.sv
module dram_err_injector
  import dram_inj_pkg::*;
#(
  parameter int WW    = WORD_W,
  parameter int NDATA = DATA_WORDS,
  parameter int QW    = QUAD_W,
  localparam int NWORD  = NDATA + 1,
  localparam int BEAT_W = WW * NWORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              beat_vld,
  input  logic [QW-1:0]     beat_quad,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              out_vld,
  output logic [BEAT_W-1:0] out_data
);
  logic             inj_fire, ecc_en, wr_req, rearm;
  logic [QW-1:0]    quad_sel;
  logic [NWORD-1:0] word_mask;
  logic [WW-1:0]    err_vec;

  dram_inj_regs #(.VEC_W(WW), .MASK_W(NWORD), .QW(QW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inj_fire(inj_fire),
    .ecc_en(ecc_en), .quad_sel(quad_sel), .word_mask(word_mask),
    .err_vec(err_vec), .wr_req(wr_req), .rearm(rearm)
  );

  dram_inj_path #(.WW(WW), .NDATA(NDATA), .QW(QW)) u_path (
    .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_quad(beat_quad),
    .beat_data(beat_data), .arm(wr_req), .ecc_en(ecc_en), .quad_sel(quad_sel),
    .word_mask(word_mask), .err_vec(err_vec), .out_vld(out_vld),
    .out_data(out_data), .inj_fire(inj_fire)
  );

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire && !rearm |=> !inj_fire); // R6
  AST_FIRE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |-> wr_req && ecc_en); // R8
endmodule

// File: tb/dram_err_injector_tb.sv
module dram_err_injector_tb;
  localparam int CLK_NS = 20;
  localparam int BW = 144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic beat_vld = 1'b0;
  logic [1:0] beat_quad = '0;
  logic [BW-1:0] beat_data = '0;
  logic out_vld;
  logic [BW-1:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  dram_err_injector u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_vld(beat_vld),
    .beat_quad(beat_quad), .beat_data(beat_data), .out_vld(out_vld),
    .out_data(out_data)
  );

  // {quad[58:57], mask[56:48], vec[47:32], seed[31:0]}
  localparam logic [58:0] TBL [6] = '{
    {2'd0, 9'h001, 16'h0001, 32'h1357_2468},
    {2'd1, 9'h100, 16'hFFFF, 32'h0101_ABCD},
    {2'd2, 9'h1FF, 16'h8000, 32'h7777_0F0F},
    {2'd3, 9'h0AA, 16'h5A5A, 32'h1234_5678},
    {2'd1, 9'h155, 16'h00F0, 32'hFFFF_0000},
    {2'd2, 9'h081, 16'hC003, 32'h0003_9999}
  };

  function automatic logic [BW-1:0] mk_beat(input logic [31:0] seed);
    logic [BW-1:0] b;
    for (int w = 0; w < 9; w++) b[w*16 +: 16] = seed[15:0] + 16'(w) * seed[31:16] + 16'(w);
    return b;
  endfunction

  function automatic logic [BW-1:0] corrupt(input logic [BW-1:0] b, input logic [8:0] m,
                                            input logic [15:0] v);
    logic [BW-1:0] r;
    r = b;
    for (int w = 0; w < 9; w++) if (m[w]) r[w*16 +: 16] = r[w*16 +: 16] ^ v;
    return r;
  endfunction

  task automatic chk(input logic [BW-1:0] act, input logic [BW-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send_beat(input logic [1:0] q, input logic [BW-1:0] d,
                           output logic [BW-1:0] res, output logic v);
    @(negedge clk);
    beat_vld = 1'b1; beat_quad = q; beat_data = d;
    @(negedge clk);
    beat_vld = 1'b0;
    res = out_data; v = out_vld;
  endtask

  function automatic logic [31:0] port_word(input logic [8:0] m, input logic [15:0] v,
                                            input logic wr, input logic rd, input logic ee);
    return {3'b0, m, 1'b0, ee, wr, rd, v};
  endfunction

  function automatic logic [31:0] sel_word(input logic [3:0] t, input logic [1:0] q);
    return {t, 25'b0, q, 1'b0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [BW-1:0] res, b, b2;
    logic v;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(BW'(out_vld), '0, "R1 out_vld");
    reg_read(2'd0, rd); chk(BW'(rd), '0, "R1 ctrl");
    reg_read(2'd1, rd); chk(BW'(rd), '0, "R1 selector");
    reg_read(2'd2, rd); chk(BW'(rd), '0, "R1 port");
    rst_n = 1'b1;

    // R4: clean pass-through, one-cycle latency
    b = mk_beat(32'hDEAD_BEEF);
    send_beat(2'd0, b, res, v);
    chk(res, b, "R4 idle data");
    chk(BW'(v), BW'(1), "R4 out_vld");
    @(negedge clk);
    chk(BW'(out_vld), '0, "R4 out_vld single");

    // R2: control register
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, rd); chk(BW'(rd), BW'(32'h0040_0000), "R2 ctrl readback");
    reg_read(2'd3, rd); chk(BW'(rd), '0, "R2 code3 reads zero");

    // R3: port writes ignored with wrong target
    reg_write(2'd2, port_word(9'h1FF, 16'hFFFF, 1, 1, 1));
    reg_read(2'd2, rd); chk(BW'(rd), '0, "R3 target 0");
    reg_write(2'd1, sel_word(4'h7, 2'd0));
    reg_write(2'd2, port_word(9'h1FF, 16'hFFFF, 1, 1, 1));
    reg_read(2'd2, rd); chk(BW'(rd), '0, "R3 target 7");
    b = mk_beat(32'h0BAD_F00D);
    send_beat(2'd0, b, res, v); chk(res, b, "R3 beat untouched");

    // R2: selector readback
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, rd); chk(BW'(rd), BW'(32'hF000_0006), "R2 selector readback");

    // R5/R6: table of injections
    for (int i = 0; i < 6; i++) begin
      logic [1:0] q; logic [8:0] m; logic [15:0] vv; logic [31:0] s;
      {q, m, vv, s} = TBL[i];
      reg_write(2'd1, sel_word(4'h8, q));
      reg_write(2'd2, port_word(m, vv, 1, 0, 0));
      reg_read(2'd2, rd); chk(BW'(rd), BW'(port_word(m, vv, 1, 0, 0)), "R2 port readback");
      b = mk_beat(s);
      send_beat(q, b, res, v);
      chk(res, corrupt(b, m, vv), "R5 injected beat");
      reg_read(2'd2, rd); chk(BW'(rd[17]), '0, "R6 request cleared");
      b2 = mk_beat(~s);
      send_beat(q, b2, res, v);
      chk(res, b2, "R6 second beat clean");
    end

    // R7: quadrant mismatch
    reg_write(2'd1, sel_word(4'h8, 2'd2));
    reg_write(2'd2, port_word(9'h003, 16'h00FF, 1, 0, 0));
    b = mk_beat(32'h4444_1111);
    send_beat(2'd1, b, res, v); chk(res, b, "R7 other quadrant clean");
    reg_read(2'd2, rd); chk(BW'(rd[17]), BW'(1), "R7 still pending");
    send_beat(2'd2, b, res, v); chk(res, corrupt(b, 9'h003, 16'h00FF), "R7 match injects");

    // R8: ECC checking disabled
    reg_write(2'd0, 32'h0);
    reg_write(2'd2, port_word(9'h010, 16'h1234, 1, 0, 0));
    b = mk_beat(32'h2222_3333);
    send_beat(2'd2, b, res, v); chk(res, b, "R8 off no corruption");
    reg_read(2'd2, rd); chk(BW'(rd[17]), BW'(1), "R8 pending while off");
    reg_write(2'd0, 32'h0040_0000);
    send_beat(2'd2, b, res, v); chk(res, corrupt(b, 9'h010, 16'h1234), "R8 injects once on");

    // R9: read request and error enable have no write-path effect
    reg_write(2'd2, port_word(9'h1FF, 16'hFFFF, 0, 1, 1));
    reg_read(2'd2, rd); chk(BW'(rd), BW'(port_word(9'h1FF, 16'hFFFF, 0, 1, 1)), "R9 readback");
    b = mk_beat(32'h5555_6666);
    send_beat(2'd2, b, res, v); chk(res, b, "R9 no injection");

    // R10: port write collides with injecting beat
    reg_write(2'd2, port_word(9'h001, 16'h000F, 1, 0, 0));
    b = mk_beat(32'h9999_AAAA);
    @(negedge clk);
    beat_vld = 1'b1; beat_quad = 2'd2; beat_data = b;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = port_word(9'h100, 16'hF000, 1, 0, 0);
    @(negedge clk);
    beat_vld = 1'b0; reg_wr = 1'b0;
    chk(out_data, corrupt(b, 9'h001, 16'h000F), "R10 old settings used");
    reg_read(2'd2, rd); chk(BW'(rd), BW'(port_word(9'h100, 16'hF000, 1, 0, 0)), "R10 new value kept");
    b2 = mk_beat(32'h1111_2222);
    send_beat(2'd2, b2, res, v); chk(res, corrupt(b2, 9'h100, 16'hF000), "R10 rearmed injects");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule